// File: doc/BRIEF.md
# Mode-Dependent General-Purpose I/O Port

This block is an 8-pin general-purpose I/O port for a processor subsystem. Each pin has a direction bit and a data bit. A direction bit of 1 turns the pin into a driven output. A direction bit of 0 leaves the pin undriven, and its level can then be read through a two-stage synchroniser. A simple single-cycle write strobe with a one-bit register select updates either register. A read of the data address returns a mix: the data bit for output pins and the synchronised pin level for input pins. The direction register cannot be read back, and a read of its address always returns all ones.

A two-bit operating-mode input is captured at the first clock edge after reset. Codes 2'b10 and 2'b11 are the wide-address modes; 2'b00 and 2'b01 are the narrow modes. In a wide-address mode the top pin belongs to the address bus. It is always an output, it carries a dedicated address-bit input, and software cannot take it back. A per-pin pulse-output source can replace the data bit on any pin, but only on pins whose direction bit is 1.

The port has two standby inputs. Hardware standby puts both registers back to their reset contents. Software standby freezes the registers while driven pins keep driving.

Top module: `gpio_port_ctrl`

## Requirements
- R1: For every pin that the mode does not own, `pin_oe_o` bit i equals the stored direction bit i. An output pin drives `pin_o`, and an input pin has `pin_oe_o` = 0 and `pin_o` = 0.
- R2: While `reg_sel_i` = 0 (direction address), `rdata_o` is 8'hFF, whatever is stored.
- R3: After reset with `mode_i` = 2'b00 or 2'b01, `pin_oe_o` is 8'h00, during reset and after it.
- R4: After reset with `mode_i` = 2'b10 or 2'b11, `pin_oe_o` is 8'h80 and `pin_o[7]` follows `addr_bit_i`.
- R5: In a wide-address mode, bit 7 stays enabled whatever value is written to the direction register. `pin_o[7]` carries `addr_bit_i` regardless of the data bit and of the pulse source.
- R6: While `sw_stby_i` = 1 and `hw_stby_i` = 0, writes are ignored, and pins that were driven keep driving the same sources.
- R7: A clock edge with `hw_stby_i` = 1 clears the direction and data registers, so the mode-owned pin 7 is the only output left. Writes in that cycle are ignored.
- R8: When `pulse_en_i[i]` = 1 and pin i is an output, `pin_o[i]` = `pulse_val_i[i]`. When pin i is an input, the pulse source does not reach the pin.
- R9: A write with `reg_sel_i` = 1 loads the data register. A read with `reg_sel_i` = 1 returns the data bit for output pins and, for input pins, `pin_i` delayed by two clock edges.
- R10: A change of `mode_i` after the capturing edge has no effect, even across hardware standby, until the next reset.
- R11: A write takes effect at the next rising clock edge and not before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| mode_i | input | 2 | Operating mode, captured at the first edge after reset |
| hw_stby_i | input | 1 | Hardware standby: clears the registers |
| sw_stby_i | input | 1 | Software standby: freezes the registers |
| wr_en_i | input | 1 | Single-cycle write strobe |
| reg_sel_i | input | 1 | Register select: 0 direction, 1 data |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for the selected register |
| addr_bit_i | input | 1 | Address bit driven on pin 7 in wide-address modes |
| pulse_en_i | input | 8 | Per-pin select of the pulse-output source |
| pulse_val_i | input | 8 | Pulse-output values |
| pin_i | input | 8 | External pin levels |
| pin_o | output | 8 | Pin output values |
| pin_oe_o | output | 8 | Pin output enables |

## Verification
The bench goes after the top pin in wide-address modes. It writes zero to bit 7 of the direction register and enables the pulse source on pin 7. A design that stored the bit plainly, or that let the pulse through, would drop the address line. It changes `mode_i` after reset and then enters hardware standby, which catches a design that samples the mode continuously or at standby. It writes during software standby and checks that output enables and pin values stay put. It also measures the exact two-edge latency of input readback, so that a missing or extra synchroniser stage shows up as a wrong value in a specific cycle.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;

  // Register select on the bus side.
  typedef enum logic {
    SEL_DIR  = 1'b0,
    SEL_DATA = 1'b1
  } reg_sel_e;

  localparam int unsigned MODE_W = 2;

  // Modes 2'b10 and 2'b11 give the top pin to the address bus.
  function automatic logic mode_is_wide(input logic [MODE_W-1:0] mode);
    return (mode >= 2'd2);
  endfunction

endpackage

// File: rtl/gpio_mode_latch.sv
module gpio_mode_latch
  import gpio_port_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [MODE_W-1:0] mode_i,
  output logic              wide_o
);

  logic init_q, init_d;
  logic wide_q, wide_d;
  logic cap_en;

  // Capture happens once, at the first edge after reset.
  assign cap_en = init_q;

  always_comb begin
    init_d = 1'b0;
    wide_d = mode_is_wide(mode_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      init_q <= 1'b1;
      wide_q <= 1'b0;
    end else if (cap_en) begin
      init_q <= init_d;
      wide_q <= wide_d;
    end
  end

  // Before the capture edge, the live input decides the mode.
  assign wide_o = init_q ? mode_is_wide(mode_i) : wide_q;

endmodule

// File: rtl/gpio_reg_file.sv
module gpio_reg_file
  import gpio_port_pkg::*;
#(
  parameter int unsigned PORT_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hw_stby_i,
  input  logic              sw_stby_i,
  input  logic              wr_en_i,
  input  reg_sel_e          wr_sel_i,
  input  logic [PORT_W-1:0] wdata_i,
  output logic [PORT_W-1:0] dir_q_o,
  output logic [PORT_W-1:0] data_q_o
);

  logic [PORT_W-1:0] dir_q, dir_d;
  logic [PORT_W-1:0] data_q, data_d;
  logic              wr_ok;
  logic              upd_en;

  assign wr_ok  = wr_en_i && !sw_stby_i && !hw_stby_i;
  assign upd_en = hw_stby_i || wr_ok;

  always_comb begin
    dir_d  = dir_q;
    data_d = data_q;
    if (hw_stby_i) begin
      dir_d  = '0;
      data_d = '0;
    end else if (wr_ok) begin
      if (wr_sel_i == SEL_DIR) dir_d  = wdata_i;
      else                     data_d = wdata_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q  <= '0;
      data_q <= '0;
    end else if (upd_en) begin
      dir_q  <= dir_d;
      data_q <= data_d;
    end
  end

  assign dir_q_o  = dir_q;
  assign data_q_o = data_q;

endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int unsigned PORT_W = 8,
  parameter int unsigned STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [PORT_W-1:0] async_i,
  output logic [PORT_W-1:0] sync_o
);

  logic [PORT_W-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    logic [PORT_W-1:0] stage_d;
    if (s == 0) begin : g_first
      assign stage_d = async_i;
    end else begin : g_rest
      assign stage_d = stage_q[s-1];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stage_q[s] <= '0;
      else        stage_q[s] <= stage_d;
    end
  end

  assign sync_o = stage_q[STAGES-1];

endmodule

// File: rtl/gpio_pin_mux.sv
module gpio_pin_mux
  import gpio_port_pkg::*;
#(
  parameter int unsigned PORT_W = 8
) (
  input  logic              wide_i,
  input  logic [PORT_W-1:0] dir_q_i,
  input  logic [PORT_W-1:0] data_q_i,
  input  logic              addr_bit_i,
  input  logic [PORT_W-1:0] pulse_en_i,
  input  logic [PORT_W-1:0] pulse_val_i,
  input  logic [PORT_W-1:0] sync_i,
  input  reg_sel_e          rd_sel_i,
  output logic [PORT_W-1:0] pin_o,
  output logic [PORT_W-1:0] pin_oe_o,
  output logic [PORT_W-1:0] rdata_o
);

  localparam int unsigned TOP = PORT_W - 1;

  logic [PORT_W-1:0] dir_eff;
  logic [PORT_W-1:0] drive_val;
  logic [PORT_W-1:0] readback;

  for (genvar i = 0; i < PORT_W; i++) begin : g_pin
    logic gp_val;
    assign gp_val = pulse_en_i[i] ? pulse_val_i[i] : data_q_i[i];
    if (i == TOP) begin : g_top
      assign dir_eff[i]   = dir_q_i[i] | wide_i;
      assign drive_val[i] = wide_i ? addr_bit_i : gp_val;
    end else begin : g_low
      assign dir_eff[i]   = dir_q_i[i];
      assign drive_val[i] = gp_val;
    end
    assign pin_o[i]    = dir_eff[i] & drive_val[i];
    assign readback[i] = dir_eff[i] ? data_q_i[i] : sync_i[i];
  end

  assign pin_oe_o = dir_eff;
  assign rdata_o  = (rd_sel_i == SEL_DIR) ? {PORT_W{1'b1}} : readback;

endmodule

// File: rtl/gpio_port_ctrl.sv
module gpio_port_ctrl
  import gpio_port_pkg::*;
#(
  parameter int unsigned PORT_W      = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [MODE_W-1:0] mode_i,
  input  logic              hw_stby_i,
  input  logic              sw_stby_i,
  input  logic              wr_en_i,
  input  logic              reg_sel_i,
  input  logic [PORT_W-1:0] wdata_i,
  output logic [PORT_W-1:0] rdata_o,
  input  logic              addr_bit_i,
  input  logic [PORT_W-1:0] pulse_en_i,
  input  logic [PORT_W-1:0] pulse_val_i,
  input  logic [PORT_W-1:0] pin_i,
  output logic [PORT_W-1:0] pin_o,
  output logic [PORT_W-1:0] pin_oe_o
);

  reg_sel_e          sel;
  logic              wide;
  logic [PORT_W-1:0] dir_q;
  logic [PORT_W-1:0] data_q;
  logic [PORT_W-1:0] pin_sync;

  assign sel = reg_sel_e'(reg_sel_i);

  gpio_mode_latch u_mode (
    .clk    (clk),
    .rst_n  (rst_n),
    .mode_i (mode_i),
    .wide_o (wide)
  );

  gpio_reg_file #(.PORT_W(PORT_W)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .hw_stby_i (hw_stby_i),
    .sw_stby_i (sw_stby_i),
    .wr_en_i   (wr_en_i),
    .wr_sel_i  (sel),
    .wdata_i   (wdata_i),
    .dir_q_o   (dir_q),
    .data_q_o  (data_q)
  );

  gpio_in_sync #(.PORT_W(PORT_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .async_i (pin_i),
    .sync_o  (pin_sync)
  );

  gpio_pin_mux #(.PORT_W(PORT_W)) u_mux (
    .wide_i      (wide),
    .dir_q_i     (dir_q),
    .data_q_i    (data_q),
    .addr_bit_i  (addr_bit_i),
    .pulse_en_i  (pulse_en_i),
    .pulse_val_i (pulse_val_i),
    .sync_i      (pin_sync),
    .rd_sel_i    (sel),
    .pin_o       (pin_o),
    .pin_oe_o    (pin_oe_o),
    .rdata_o     (rdata_o)
  );

endmodule

// File: rtl/gpio_port_chk.sv
module gpio_port_chk
  import gpio_port_pkg::*;
#(
  parameter int unsigned PORT_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic [MODE_W-1:0] mode_i,
  input logic              hw_stby_i,
  input logic              sw_stby_i,
  input logic              wr_en_i,
  input logic              reg_sel_i,
  input logic [PORT_W-1:0] wdata_i,
  input logic [PORT_W-1:0] rdata_o,
  input logic              addr_bit_i,
  input logic [PORT_W-1:0] pulse_en_i,
  input logic [PORT_W-1:0] pulse_val_i,
  input logic [PORT_W-1:0] pin_i,
  input logic [PORT_W-1:0] pin_o,
  input logic [PORT_W-1:0] pin_oe_o
);

  localparam int unsigned TOP = PORT_W - 1;

  // Checker keeps its own record of the captured mode.
  logic chk_init;
  logic chk_wide;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chk_init <= 1'b1;
      chk_wide <= 1'b0;
    end else if (chk_init) begin
      chk_init <= 1'b0;
      chk_wide <= (mode_i[1] == 1'b1);
    end
  end

  a_r2_dir_reads_ones: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_sel_i == 1'b0) |-> (rdata_o == {PORT_W{1'b1}}));

  a_r5_top_pin_owned: assert property (@(posedge clk) disable iff (!rst_n)
    (!chk_init && chk_wide) |-> (pin_oe_o[TOP] && (pin_o[TOP] == addr_bit_i)));

  a_r6_sw_stby_freezes_oe: assert property (@(posedge clk) disable iff (!rst_n)
    (!chk_init && sw_stby_i && !hw_stby_i) |=> $stable(pin_oe_o));

  a_r7_hw_stby_clears: assert property (@(posedge clk) disable iff (!rst_n)
    hw_stby_i |=> (pin_oe_o[TOP-1:0] == '0));

  a_r11_dir_write_next_edge: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && !reg_sel_i && !sw_stby_i && !hw_stby_i)
      |=> (pin_oe_o[TOP-1:0] == $past(wdata_i[TOP-1:0])));

endmodule

bind gpio_port_ctrl gpio_port_chk #(.PORT_W(PORT_W)) u_chk (.*);

// File: tb/tb_gpio_port_ctrl.sv
module tb_gpio_port_ctrl;

  logic       clk;
  logic       rst_n;
  logic [1:0] mode_i;
  logic       hw_stby_i, sw_stby_i, wr_en_i, reg_sel_i, addr_bit_i;
  logic [7:0] wdata_i, pulse_en_i, pulse_val_i, pin_i;
  logic [7:0] rdata_o, pin_o, pin_oe_o;

  int checks = 0;
  int failures = 0;

  // Reference model state
  logic [7:0] m_dir, m_data, m_s1, m_s2;
  logic       m_init, m_wide;

  gpio_port_ctrl dut (
    .clk(clk), .rst_n(rst_n), .mode_i(mode_i), .hw_stby_i(hw_stby_i),
    .sw_stby_i(sw_stby_i), .wr_en_i(wr_en_i), .reg_sel_i(reg_sel_i),
    .wdata_i(wdata_i), .rdata_o(rdata_o), .addr_bit_i(addr_bit_i),
    .pulse_en_i(pulse_en_i), .pulse_val_i(pulse_val_i), .pin_i(pin_i),
    .pin_o(pin_o), .pin_oe_o(pin_oe_o)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  function automatic logic cur_wide();
    return m_init ? mode_i[1] : m_wide;
  endfunction

  function automatic logic [7:0] exp_oe();
    return m_dir | (cur_wide() ? 8'h80 : 8'h00);
  endfunction

  function automatic logic [7:0] exp_pin();
    logic [7:0] v;
    v = (pulse_en_i & pulse_val_i) | (~pulse_en_i & m_data);
    if (cur_wide()) v[7] = addr_bit_i;
    return v & exp_oe();
  endfunction

  function automatic logic [7:0] exp_rd();
    if (!reg_sel_i) return 8'hFF;
    return (m_data & exp_oe()) | (m_s2 & ~exp_oe());
  endfunction

  task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s actual=%02h expected=%02h at %0t", req, got, exp, $time);
    end
  endtask

  task automatic check_all();
    check("R1", pin_oe_o, exp_oe());
    check("R8", pin_o, exp_pin());
    check(reg_sel_i ? "R9" : "R2", rdata_o, exp_rd());
  endtask

  task automatic idle_inputs();
    hw_stby_i = 0; sw_stby_i = 0; wr_en_i = 0; reg_sel_i = 0; wdata_i = 0;
    addr_bit_i = 0; pulse_en_i = 0; pulse_val_i = 0; pin_i = 0;
  endtask

  // One clock: model follows the edge, outputs compared at the falling edge.
  task automatic cyc();
    @(posedge clk);
    if (rst_n) begin
      if (m_init) begin m_wide = mode_i[1]; m_init = 0; end
      m_s2 = m_s1; m_s1 = pin_i;
      if (hw_stby_i) begin m_dir = 0; m_data = 0; end
      else if (!sw_stby_i && wr_en_i) begin
        if (reg_sel_i) m_data = wdata_i; else m_dir = wdata_i;
      end
    end
    @(negedge clk);
  endtask

  task automatic do_reset(input logic [1:0] md);
    @(negedge clk);
    rst_n = 0; mode_i = md; idle_inputs();
    m_dir = 0; m_data = 0; m_s1 = 0; m_s2 = 0; m_init = 1; m_wide = 0;
    @(negedge clk);
    check(md[1] ? "R4" : "R3", pin_oe_o, md[1] ? 8'h80 : 8'h00);
    rst_n = 1;
    cyc();
  endtask

  task automatic wr(input logic sel, input logic [7:0] d);
    wr_en_i = 1; reg_sel_i = sel; wdata_i = d;
    cyc();
    wr_en_i = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL R1 watchdog actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    rst_n = 0; mode_i = 0; idle_inputs();

    // Narrow mode reset state
    do_reset(2'b00);
    check("R3", pin_oe_o, 8'h00);
    check("R2", rdata_o, 8'hFF);

    // Direction write: unchanged before the edge, applied after it
    wr_en_i = 1; reg_sel_i = 0; wdata_i = 8'h0F;
    #1 check("R11", pin_oe_o, 8'h00);
    cyc(); wr_en_i = 0;
    check("R11", pin_oe_o, 8'h0F);
    check("R2", rdata_o, 8'hFF);

    // Data register and mixed readback with two-edge latency
    wr(1'b1, 8'hA5);
    check("R9", pin_o, 8'h05);
    pin_i = 8'h30; reg_sel_i = 1;
    cyc();
    check("R9", rdata_o, 8'h05);
    cyc();
    check("R9", rdata_o, 8'h35);

    // Pulse source only on output pins
    pulse_en_i = 8'hFF; pulse_val_i = 8'hC3;
    #1 check("R8", pin_o, 8'h03);
    check("R1", pin_oe_o, 8'h0F);

    // Software standby freezes registers, outputs keep driving
    sw_stby_i = 1;
    wr(1'b0, 8'hFF);
    wr(1'b1, 8'h00);
    check("R6", pin_oe_o, 8'h0F);
    check("R6", pin_o, 8'h03);
    sw_stby_i = 0; pulse_en_i = 0;
    #1 check("R6", pin_o, 8'h05);

    // Hardware standby clears, write in same cycle dropped
    hw_stby_i = 1; wr_en_i = 1; reg_sel_i = 0; wdata_i = 8'hFF;
    cyc(); hw_stby_i = 0; wr_en_i = 0; reg_sel_i = 1;
    check("R7", pin_oe_o, 8'h00);
    #1 check("R7", rdata_o, 8'h30);

    // Wide mode: top pin owned by address bit
    do_reset(2'b10);
    addr_bit_i = 1;
    #1 check("R4", pin_o, 8'h80);
    check("R4", pin_oe_o, 8'h80);
    wr(1'b0, 8'h01);
    check("R5", pin_oe_o, 8'h81);
    wr(1'b1, 8'h00);
    pulse_en_i = 8'h80; pulse_val_i = 8'h00;
    #1 check("R5", pin_o, 8'h80);
    addr_bit_i = 0;
    #1 check("R5", pin_o, 8'h00);

    // Mode changes after capture are ignored, even through hardware standby
    mode_i = 2'b00; hw_stby_i = 1;
    cyc(); hw_stby_i = 0;
    check("R10", pin_oe_o, 8'h80);
    cyc();
    check("R10", pin_oe_o, 8'h80);

    do_reset(2'b01);
    check("R3", pin_oe_o, 8'h00);
    do_reset(2'b11);
    check("R4", pin_oe_o, 8'h80);
    mode_i = 2'b01;
    wr(1'b0, 8'h00);
    check("R10", pin_oe_o, 8'h80);

    // Randomised traffic against the model
    for (int n = 0; n < 3000; n++) begin
      if ($urandom_range(0, 199) == 0) do_reset(2'($urandom_range(0, 3)));
      mode_i      = 2'($urandom_range(0, 3));
      hw_stby_i   = ($urandom_range(0, 29) == 0);
      sw_stby_i   = ($urandom_range(0, 9) == 0);
      wr_en_i     = ($urandom_range(0, 1) == 0);
      reg_sel_i   = 1'($urandom_range(0, 1));
      wdata_i     = 8'($urandom);
      addr_bit_i  = 1'($urandom_range(0, 1));
      pulse_en_i  = 8'($urandom);
      pulse_val_i = 8'($urandom);
      pin_i       = 8'($urandom);
      #1 check_all();
      cyc();
      check_all();
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule